// File: doc/BRIEF.md
# Dual-Comparator Hit Timestamp Capture

This block is the digital timing stage of one sensor pixel that has two discriminators. It brings both comparator outputs into the clock domain and detects their rising edges. It keeps a free-running wrapping timestamp counter and records the counter value at each event of interest. The counter is meant to run from a 125 MHz clock.

Two operating modes are available. In the confirm mode, the first comparator sits at a low threshold and has little timewalk, so its crossing gives the hit time. The second comparator sits at a higher threshold. A hit is published only if the second comparator fires within a programmable number of cycles; otherwise the pending time is discarded as noise. In the ramp mode, the first comparator has a fixed threshold. Its crossing gives the first time and raises a ramp request. The second comparator fires when the ramp crosses the held signal level, and the time between the two events measures the pulse amplitude. If the ramp never crosses within a fixed timeout, the hit is published with an overflow flag.

Each published hit presents both times, their modular difference, an overflow bit, the mode it was taken in, and a one-cycle valid pulse. A busy flag shows that a hit is pending.

Top module: `hit_stamp_top`

## Requirements
- R1: While rstN is low, every output is zero and busy is low.
- R2: stampNow is a 10-bit counter. It rises by exactly one on every clock edge and wraps from 1023 to 0.
- R3: A first-comparator rising edge is captured with a two-flop synchroniser latency. If the input is first sampled high at edge E, the first time recorded is the stampNow value shown after edge E+1.
- R4: In confirm mode (modeSel=0), a second-comparator rise d cycles after the first-comparator rise, with 0 <= d <= confirmWin, publishes a hit. hitValid pulses for one cycle, d+3 cycles after the first input rose. hitAmp is d, hitOvf is 0 and hitMode is 0. A rise at d=confirmWin, in the window's last cycle, still counts.
- R5: In confirm mode, when no second-comparator rise arrives within confirmWin cycles, busy stays high for exactly confirmWin cycles and then falls. hitValid does not pulse, and the published hit fields keep their previous values.
- R6: In ramp mode (modeSel=1), rampReq and busy are high while waiting. A second-comparator rise at 1 <= d <= TIMEOUT publishes a hit with hitAmp=d, hitOvf=0 and hitMode=1. A rise at d=TIMEOUT, in the timeout cycle, beats the timeout.
- R7: In ramp mode, when no second-comparator rise is seen within TIMEOUT (255) cycles, a hit is published after TIMEOUT busy cycles with hitOvf=1 and hitAmp=TIMEOUT. A second-comparator rise in the same cycle as the first-comparator rise does not end the wait.
- R8: First-comparator rises while busy, and second-comparator rises while idle, are ignored. They change neither the published times nor the busy duration.
- R9: The mode is taken from modeSel when the first-comparator edge is accepted. Changing modeSel while busy does not change hitMode, rampReq or the outcome.
- R10: hitSecond equals (hitFirst + hitAmp) mod 1024, including hits that straddle the counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0 = confirm mode, 1 = ramp mode; used only when idle |
| confirmWin | input | 8 | Confirm-mode window in cycles (1 to 255; 0 acts as 1) |
| compFirstIn | input | 1 | Asynchronous first comparator (timing threshold) |
| compSecondIn | input | 1 | Asynchronous second comparator (high threshold or ramp crossing) |
| stampNow | output | 10 | Free-running timestamp counter |
| hitFirst | output | 10 | First time of the last published hit |
| hitSecond | output | 10 | Second time of the last published hit |
| hitAmp | output | 10 | Modular difference hitSecond - hitFirst |
| hitOvf | output | 1 | Ramp timeout reached for the last hit |
| hitMode | output | 1 | Mode of the last published hit |
| hitValid | output | 1 | One-cycle pulse when a hit is published |
| busy | output | 1 | A hit is pending |
| rampReq | output | 1 | Ramp start request, high while a ramp-mode hit waits |

## Verification
Two pairs of functions can land in the same cycle. The confirming or ramp-crossing edge can arrive in the very cycle the window or timeout expires, and in that case the edge must win. The two comparators can also rise together. That must publish at once in confirm mode, but must be ignored for the second comparator in ramp mode. Directed runs place the second input at d=0, d=confirmWin, d=confirmWin+1 and d=TIMEOUT, and random runs sweep d around these limits. Each outcome is judged at the ports: the pulse cycle, the busy length, and the amplitude and overflow bits are compared with bench-computed values.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_RAMP    = 2'd2
  } waitState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capFirst;   // load counter into pending first time
    logic publish;    // commit a hit to the outputs
    logic overflow;   // published hit ended by ramp timeout
    logic mode;       // mode of the published hit
  } stampStrobe_t;

endpackage

// File: rtl/hit_stamp_dpath.sv
module hit_stamp_dpath
  import hit_stamp_pkg::*;
#(
  parameter int TS_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            compFirstIn,
  input  logic            compSecondIn,
  input  stampStrobe_t    strobe,
  output logic            firstRise,
  output logic            secondRise,
  output logic [TS_W-1:0] stampNow,
  output logic [TS_W-1:0] hitFirst,
  output logic [TS_W-1:0] hitSecond,
  output logic [TS_W-1:0] hitAmp,
  output logic            hitOvf,
  output logic            hitMode,
  output logic            hitValid
);

  localparam int N_CH = 2;

  logic [N_CH-1:0] rawIn;
  logic [N_CH-1:0] riseVec;
  assign rawIn = {compSecondIn, compFirstIn};

  // one synchroniser plus edge detector per comparator channel
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
    logic meta, stable, prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= 1'b0;
        stable <= 1'b0;
        prev   <= 1'b0;
      end else begin
        meta   <= rawIn[ch];
        stable <= meta;
        prev   <= stable;
      end
    end
    assign riseVec[ch] = stable & ~prev;
  end

  assign firstRise  = riseVec[0];
  assign secondRise = riseVec[1];

  logic [TS_W-1:0] tsCnt;
  logic [TS_W-1:0] pendFirst;
  logic [TS_W-1:0] firstSrc;

  assign firstSrc = strobe.capFirst ? tsCnt : pendFirst;
  assign stampNow = tsCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsCnt     <= '0;
      pendFirst <= '0;
      hitFirst  <= '0;
      hitSecond <= '0;
      hitAmp    <= '0;
      hitOvf    <= 1'b0;
      hitMode   <= 1'b0;
      hitValid  <= 1'b0;
    end else begin
      tsCnt    <= tsCnt + 1'b1;
      hitValid <= strobe.publish;
      if (strobe.capFirst) pendFirst <= tsCnt;
      if (strobe.publish) begin
        hitFirst  <= firstSrc;
        hitSecond <= tsCnt;
        hitAmp    <= tsCnt - firstSrc;
        hitOvf    <= strobe.overflow;
        hitMode   <= strobe.mode;
      end
    end
  end

  // R7
  overflow_only_ramp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish && strobe.overflow |-> strobe.mode);

  // R3
  first_cap_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capFirst |-> firstRise);

endmodule

// File: rtl/hit_stamp_ctrl.sv
module hit_stamp_ctrl
  import hit_stamp_pkg::*;
#(
  parameter int WIN_W   = 8,
  parameter int TIMEOUT = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic [WIN_W-1:0] confirmWin,
  input  logic             firstRise,
  input  logic             secondRise,
  output stampStrobe_t     strobe,
  output logic             busy,
  output logic             rampReq
);

  localparam int TO_W  = $clog2(TIMEOUT + 1);
  localparam int CNT_W = ((TO_W > WIN_W) ? TO_W : WIN_W) + 1;
  localparam logic [CNT_W-1:0] TO_LIM = CNT_W'(TIMEOUT);

  waitState_e       state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitNext;
  logic [CNT_W-1:0] winLim;

  assign winLim = {{(CNT_W-WIN_W){1'b0}}, confirmWin};

  always_comb begin
    stateNext = state;
    waitNext  = waitCnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (firstRise) begin
          strobe.capFirst = 1'b1;
          strobe.mode     = modeSel;
          waitNext        = CNT_W'(1);
          if (!modeSel && secondRise) begin
            strobe.publish = 1'b1;   // both thresholds crossed together
          end else begin
            stateNext = modeSel ? ST_RAMP : ST_CONFIRM;
          end
        end
      end
      ST_CONFIRM: begin
        if (secondRise) begin
          strobe.publish = 1'b1;
          stateNext      = ST_IDLE;
        end else if (waitCnt >= winLim) begin
          stateNext = ST_IDLE;       // unconfirmed: drop silently
        end else begin
          waitNext = waitCnt + 1'b1;
        end
      end
      ST_RAMP: begin
        strobe.mode = 1'b1;
        if (secondRise) begin
          strobe.publish = 1'b1;
          stateNext      = ST_IDLE;
        end else if (waitCnt >= TO_LIM) begin
          strobe.publish  = 1'b1;
          strobe.overflow = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          waitNext = waitCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitNext;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign rampReq = (state == ST_RAMP);

  // R5
  confirm_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_CONFIRM |-> (waitCnt <= winLim) || (waitCnt == CNT_W'(1)));

  // R7
  ramp_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RAMP |-> waitCnt <= TO_LIM);

  // R8
  no_capture_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.capFirst);

endmodule

// File: rtl/hit_stamp_top.sv
module hit_stamp_top
  import hit_stamp_pkg::*;
#(
  parameter int TS_W    = 10,
  parameter int WIN_W   = 8,
  parameter int TIMEOUT = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic [WIN_W-1:0] confirmWin,
  input  logic             compFirstIn,
  input  logic             compSecondIn,
  output logic [TS_W-1:0]  stampNow,
  output logic [TS_W-1:0]  hitFirst,
  output logic [TS_W-1:0]  hitSecond,
  output logic [TS_W-1:0]  hitAmp,
  output logic             hitOvf,
  output logic             hitMode,
  output logic             hitValid,
  output logic             busy,
  output logic             rampReq
);

  stampStrobe_t strobe;
  logic         firstRise, secondRise;

  hit_stamp_ctrl #(.WIN_W(WIN_W), .TIMEOUT(TIMEOUT)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .confirmWin(confirmWin),
    .firstRise(firstRise), .secondRise(secondRise),
    .strobe(strobe), .busy(busy), .rampReq(rampReq)
  );

  hit_stamp_dpath #(.TS_W(TS_W)) dpath_i (
    .clk(clk), .rstN(rstN), .compFirstIn(compFirstIn), .compSecondIn(compSecondIn),
    .strobe(strobe), .firstRise(firstRise), .secondRise(secondRise),
    .stampNow(stampNow), .hitFirst(hitFirst), .hitSecond(hitSecond),
    .hitAmp(hitAmp), .hitOvf(hitOvf), .hitMode(hitMode), .hitValid(hitValid)
  );

  // R8
  stable_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(hitFirst));

  // R4
  confirm_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid && !hitMode |-> (hitAmp <= TS_W'(confirmWin)) || (hitAmp <= TS_W'(1)));

  // R7
  ovf_amp_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid && hitOvf |-> hitMode && (hitAmp == TS_W'(TIMEOUT)));

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> !busy && !rampReq);

endmodule

// File: tb/hit_stamp_top_tb_top.sv
module hit_stamp_top_tb_top;

  localparam int CLK_PERIOD = 8;
  localparam int TO_CYC     = 255;
  localparam int TSM        = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSel = 1'b0;
  logic [7:0] confirmWin = 8'd16;
  logic       compFirstIn = 1'b0;
  logic       compSecondIn = 1'b0;
  logic [9:0] stampNow, hitFirst, hitSecond, hitAmp;
  logic       hitOvf, hitMode, hitValid, busy, rampReq;

  int nVec = 0;
  int nBad = 0;
  bit cntPrimed = 1'b0;
  int cntPrev = 0;
  int lastFirst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_stamp_top dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .confirmWin(confirmWin),
    .compFirstIn(compFirstIn), .compSecondIn(compSecondIn),
    .stampNow(stampNow), .hitFirst(hitFirst), .hitSecond(hitSecond),
    .hitAmp(hitAmp), .hitOvf(hitOvf), .hitMode(hitMode),
    .hitValid(hitValid), .busy(busy), .rampReq(rampReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  // R2: counter continuity, sampled away from the clock edge
  always @(negedge clk) begin
    if (rstN) begin
      if (cntPrimed)
        check(int'(stampNow) == (cntPrev + 1) % TSM, "R2 counter step", stampNow, (cntPrev + 1) % TSM);
      cntPrev   = int'(stampNow);
      cntPrimed = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  // expected outcome computed from the requirements
  function automatic void expect_hit(input bit m, input int w, input int d, input bit hasHi,
                                     output bit valid, output int amp, output bit ovf,
                                     output int busyLen);
    int wEff;
    wEff = (w < 1) ? 1 : w;
    valid = 1'b1; ovf = 1'b0;
    if (!m) begin
      if (hasHi && d <= wEff) begin amp = d; busyLen = d; end
      else begin valid = 1'b0; amp = 0; busyLen = wEff; end
    end else begin
      if (hasHi && d >= 1 && d <= TO_CYC) begin amp = d; busyLen = d; end
      else begin amp = TO_CYC; ovf = 1'b1; busyLen = TO_CYC; end
    end
  endfunction

  task automatic run_hit(input bit m, input int w, input int d, input bit hasHi,
                         input bit extraLo, input bit flipMode);
    bit eValid, eOvf;
    int eAmp, eLen, c, maxOff, seenOff, nValid, busyCnt;
    int gFirst, gSecond, gAmp;
    bit gOvf, gMode, rampOk;
    expect_hit(m, w, d, hasHi, eValid, eAmp, eOvf, eLen);
    @(negedge clk);
    confirmWin = 8'(w);
    modeSel = m;
    compFirstIn = 1'b1;
    if (hasHi && d == 0) compSecondIn = 1'b1;
    c = int'(stampNow);
    maxOff = ((d > eLen) ? d : eLen) + 9;
    seenOff = -1; nValid = 0; busyCnt = 0; rampOk = 1'b1;
    gFirst = 0; gSecond = 0; gAmp = 0; gOvf = 1'b0; gMode = 1'b0;
    for (int off = 1; off <= maxOff; off++) begin
      @(negedge clk);
      if (busy) busyCnt++;
      if (rampReq != (busy && m)) rampOk = 1'b0;
      if (hitValid) begin
        nValid++; seenOff = off;
        gFirst = int'(hitFirst); gSecond = int'(hitSecond); gAmp = int'(hitAmp);
        gOvf = hitOvf; gMode = hitMode;
      end
      if (hasHi && off == d) compSecondIn = 1'b1;
      if (extraLo && eLen >= 8 && off == 2) compFirstIn = 1'b0;
      if (extraLo && eLen >= 8 && off == 3) compFirstIn = 1'b1;
      if (flipMode && off == 3) modeSel = ~m;
    end
    compFirstIn = 1'b0; compSecondIn = 1'b0;
    repeat (4) @(negedge clk);
    check(nValid == (eValid ? 1 : 0), m ? "R6 R7 pulse count" : "R4 R5 pulse count", nValid, eValid ? 1 : 0);
    check(busyCnt == eLen, m ? "R6 R7 R8 busy length" : "R4 R5 R8 busy length", busyCnt, eLen);
    check(rampOk, "R6 rampReq tracks ramp wait", rampOk, 1);
    if (eValid) begin
      check(seenOff == eLen + 3, "R4 R6 pulse cycle", seenOff, eLen + 3);
      check(gFirst == (c + 2) % TSM, "R3 first time", gFirst, (c + 2) % TSM);
      check(gAmp == eAmp, m ? "R6 R7 amplitude" : "R4 amplitude", gAmp, eAmp);
      check(gSecond == (gFirst + gAmp) % TSM, "R10 modular second time", gSecond, (gFirst + gAmp) % TSM);
      check(gOvf == eOvf, "R7 overflow flag", gOvf, eOvf);
      check(gMode == m, "R9 mode of hit", gMode, m);
      lastFirst = gFirst;
    end else begin
      check(int'(hitFirst) == lastFirst, "R5 outputs kept on drop", hitFirst, lastFirst);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    check(stampNow == 0 && hitFirst == 0 && hitSecond == 0 && hitAmp == 0, "R1 reset times", stampNow, 0);
    check(!hitOvf && !hitMode && !hitValid && !busy && !rampReq, "R1 reset flags",
          {hitOvf, hitMode, hitValid, busy, rampReq}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // directed confirm-mode corners
    run_hit(1'b0, 16, 0, 1'b1, 1'b0, 1'b0);   // R4 simultaneous rise
    run_hit(1'b0, 16, 16, 1'b1, 1'b1, 1'b1);  // R4 last window cycle, R8, R9
    run_hit(1'b0, 16, 17, 1'b1, 1'b0, 1'b0);  // R5 one too late, R8 idle rise
    run_hit(1'b0, 5, 0, 1'b0, 1'b0, 1'b0);    // R5 never confirmed
    // directed ramp-mode corners
    run_hit(1'b1, 16, 1, 1'b1, 1'b0, 1'b0);   // R6 shortest ramp
    run_hit(1'b1, 16, 0, 1'b1, 1'b0, 1'b0);   // R7 coincident second edge ignored
    run_hit(1'b1, 16, TO_CYC, 1'b1, 1'b1, 1'b1); // R6 edge in timeout cycle
    run_hit(1'b1, 16, 0, 1'b0, 1'b0, 1'b0);   // R7 timeout overflow
    // R10 straddle the counter wrap
    while (stampNow != 10'd1015) @(negedge clk);
    run_hit(1'b1, 16, 12, 1'b1, 1'b0, 1'b0);

    for (int it = 0; it < 70; it++) begin
      bit m, hasHi;
      int w, d;
      m = 1'($urandom % 2);
      w = 1 + int'($urandom % 20);
      hasHi = ($urandom % 5) != 0;
      if (!m) d = int'($urandom % (w + 4));
      else    d = int'($urandom % 40);
      run_hit(m, w, d, hasHi, 1'($urandom % 2), 1'($urandom % 2));
    end
    summary();
  end

endmodule